// File: doc/BRIEF.md
# Iterative Integer Square Root Unit

This block computes the integer square root of an unsigned radicand of even width `RAD_W`. It returns the root, `RAD_W/2` bits wide, and the remainder left after the root is squared. It finds one root bit per clock cycle, most significant bit first. Each step shifts the running remainder left by two and brings in the next pair of radicand bits from the top. It then subtracts a trial value formed from the partial root with `01` placed below it. When that difference is non-negative, the root bit is 1 and the difference becomes the new remainder. Otherwise the root bit is 0 and the shifted remainder is kept as it is. No add-back step exists, and one subtractor is shared by every iteration.

A two-state controller sequences the work. In `ST_IDLE` the block shows `ready`. A `start` pulse there is the transition *launch*: it captures the radicand, clears the partial root and the remainder, and moves to `ST_RUN`. `ST_RUN` repeats the transition *iterate* once per cycle until the final root bit is written. It then takes the transition *finish* back to `ST_IDLE` and raises `done` for one cycle. The results stay unchanged until the next launch.

Top module: `isqrt_unit`

## Requirements
- R1: While reset is held and right after it is released, `ready`=1, `done`=0, `root`=0 and `remainder`=0.
- R2: A `start` sampled high at a clock edge while `ready`=1 captures `radicand`, and `ready` reads 0 after that edge. Changing `radicand` afterwards does not alter the result.
- R3: `done` is high for exactly one cycle, namely the cycle after the `RAD_W/2`-th rising edge following the accepting edge. `ready` returns to 1 in that same cycle.
- R4: When `done` is high, `root` equals floor(sqrt(radicand)). For example, 169 gives 13.
- R5: When `done` is high, `remainder` equals radicand − root², and it never exceeds 2·root.
- R6: A radicand of 0 gives root 0 and remainder 0. An all-ones radicand gives an all-ones root and a remainder of 2·root.
- R7: A `start` raised while `ready`=0 is ignored. The result and the timing of `done` are those of the computation already under way.
- R8: After `done`, `root` and `remainder` hold their values and `done` stays low until the next accepted `start`.
- R9: A `start` raised in the same cycle as `done` is accepted. The next result then follows with the latency given in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a computation; taken only when `ready` is high |
| radicand | input | RAD_W | Unsigned value whose root is wanted |
| ready | output | 1 | High in `ST_IDLE`, when a new `start` can be accepted |
| done | output | 1 | One-cycle pulse when the result becomes valid |
| root | output | RAD_W/2 | Integer square root |
| remainder | output | RAD_W/2+2 | radicand − root² |

## Verification
The accepting edge is counted as edge 0. `ready` falls by the first half-cycle after it. `done`, `root` and `remainder` become valid in the half-cycle after edge `RAD_W/2`, and `done` is gone again one cycle later. The bench drives inputs and samples outputs on the falling edge. It counts exactly `RAD_W/2` rising edges from the accepting edge before it reads a result. It also checks that `done` is still low one cycle earlier and low again one cycle later. Start pulses issued during a run and a start issued on the `done` cycle are timed the same way, so any change in latency appears as a mismatch.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } isqrt_state_e;
endpackage

// File: rtl/isqrt_step.sv
// One trial subtraction: shift in a radicand pair, try {partial_root, 01}.
module isqrt_step #(
    parameter int ROOT_W = 8,
    localparam int REM_W = ROOT_W + 2
) (
    input  logic [REM_W-1:0]  rem_i,
    input  logic [1:0]        pair_i,
    input  logic [ROOT_W-1:0] root_i,
    output logic [REM_W-1:0]  rem_o,
    output logic              bit_o
);
    logic [REM_W-1:0] shifted;
    logic [REM_W-1:0] trial;
    logic [REM_W:0]   diff;

    always_comb begin
        shifted = {rem_i[REM_W-3:0], pair_i};
        trial   = {root_i, 2'b01};
        diff    = {1'b0, shifted} - {1'b0, trial};
        bit_o   = ~diff[REM_W];
        // negative trial: remainder kept, nothing added back
        rem_o   = bit_o ? diff[REM_W-1:0] : shifted;
    end
endmodule

// File: rtl/isqrt_dpath.sv
// Shared registers: radicand shifter, partial root, running remainder.
module isqrt_dpath #(
    parameter int RAD_W = 16,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = ROOT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [RAD_W-1:0]  radicand,
    output logic [ROOT_W-1:0] root_o,
    output logic [REM_W-1:0]  rem_o
);
    logic [RAD_W-1:0]  rad_q;
    logic [ROOT_W-1:0] root_q;
    logic [REM_W-1:0]  rem_q;
    logic [REM_W-1:0]  rem_next;
    logic              bit_next;

    isqrt_step #(.ROOT_W(ROOT_W)) u_step (
        .rem_i  (rem_q),
        .pair_i (rad_q[RAD_W-1 -: 2]),
        .root_i (root_q),
        .rem_o  (rem_next),
        .bit_o  (bit_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rad_q  <= '0;
            root_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            rad_q  <= radicand;
            root_q <= '0;
            rem_q  <= '0;
        end else if (step) begin
            rad_q  <= {rad_q[RAD_W-3:0], 2'b00};
            root_q <= {root_q[ROOT_W-2:0], bit_next};
            rem_q  <= rem_next;
        end
    end

    assign root_o = root_q;
    assign rem_o  = rem_q;

    // remainder bounded by twice the partial root at every step
    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (rst)
        rem_q <= {1'b0, root_q, 1'b0});
endmodule

// File: rtl/isqrt_ctrl.sv
// Two-state sequencer: launch, iterate, finish.
module isqrt_ctrl
    import isqrt_pkg::*;
#(
    parameter int ROOT_W = 8,
    localparam int CNT_W = $clog2(ROOT_W) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic ready,
    output logic load,
    output logic step,
    output logic done
);
    isqrt_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last;
    logic             done_q;

    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        last = step && (cnt_q == CNT_W'(ROOT_W - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;   // launch
            ST_RUN:  if (last)  state_d = ST_IDLE;  // finish, else iterate
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= last;
    end

    assign ready = (state_q == ST_IDLE);
    assign done  = done_q;

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        step |-> (cnt_q < CNT_W'(ROOT_W)));
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> (step && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit #(
    parameter int RAD_W = 16,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = ROOT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RAD_W-1:0]  radicand,
    output logic              ready,
    output logic              done,
    output logic [ROOT_W-1:0] root,
    output logic [REM_W-1:0]  remainder
);
    logic load, step;

    isqrt_ctrl #(.ROOT_W(ROOT_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ready (ready),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    isqrt_dpath #(.RAD_W(RAD_W)) u_dpath (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .radicand (radicand),
        .root_o   (root),
        .rem_o    (remainder)
    );

    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_ready_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && !start && !done) |=> ($stable(root) && $stable(remainder)));
endmodule

// File: tb/sim_isqrt_unit.sv
module sim_isqrt_unit;
    localparam int RAD_W  = 16;
    localparam int ROOT_W = RAD_W / 2;
    localparam int REM_W  = ROOT_W + 2;
    localparam int NVEC   = 18;

    localparam logic [31:0] VEC_X [NVEC] = '{
        32'd169, 32'd0, 32'd1, 32'd2, 32'd3, 32'd4, 32'd15, 32'd16,
        32'd255, 32'd256, 32'd1000, 32'd4096, 32'd65535, 32'd65025,
        32'd65024, 32'd12345, 32'd50000, 32'd43690 };
    localparam logic [31:0] VEC_R [NVEC] = '{
        32'd13, 32'd0, 32'd1, 32'd1, 32'd1, 32'd2, 32'd3, 32'd4,
        32'd15, 32'd16, 32'd31, 32'd64, 32'd255, 32'd255,
        32'd254, 32'd111, 32'd223, 32'd209 };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [RAD_W-1:0]  radicand = '0;
    logic ready, done;
    logic [ROOT_W-1:0] root;
    logic [REM_W-1:0]  remainder;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    isqrt_unit #(.RAD_W(RAD_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .radicand(radicand),
        .ready(ready), .done(done), .root(root), .remainder(remainder)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at negedge, accepted at next posedge (edge 0)
    task automatic launch(input logic [RAD_W-1:0] x);
        @(negedge clk);
        start = 1'b1;
        radicand = x;
        @(negedge clk);
        start = 1'b0;
        radicand = ~x;
    endtask

    // called right after launch (just past edge 0); checks result at edge ROOT_W
    task automatic finish_one(input logic [31:0] x, input logic [31:0] er, input string tag);
        logic [31:0] erem;
        erem = x - er * er;
        check(ready == 1'b0, {tag, " R2 ready low"}, 32'(ready), 0);
        repeat (ROOT_W - 1) @(negedge clk);
        check(done == 1'b0, {tag, " R3 no early done"}, 32'(done), 0);
        @(negedge clk);
        check(done == 1'b1 && ready == 1'b1, {tag, " R3 done+ready"}, 32'({done, ready}), 3);
        check(32'(root) == er, {tag, " R4 root"}, 32'(root), er);
        check(32'(remainder) == erem, {tag, " R5 remainder"}, 32'(remainder), erem);
    endtask

    task automatic check_hold(input logic [31:0] er, input string tag);
        @(negedge clk);
        check(done == 1'b0, {tag, " R8 done low"}, 32'(done), 0);
        check(32'(root) == er, {tag, " R8 root held"}, 32'(root), er);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(ready == 1'b1 && done == 1'b0, "R1 ready/done in reset", 32'({ready, done}), 2);
        rst = 1'b0;
        @(negedge clk);
        check(ready == 1'b1 && done == 1'b0, "R1 ready/done after reset", 32'({ready, done}), 2);
        check(root == '0 && remainder == '0, "R1 outputs zero", 32'(root), 0);

        // vector table: R4/R5, incl. R6 zero and all-ones entries
        for (int i = 0; i < NVEC; i++) begin
            launch(VEC_X[i][RAD_W-1:0]);
            finish_one(VEC_X[i], VEC_R[i], $sformatf("vec%0d", i));
            if (VEC_X[i] == 32'd0)
                check(remainder == '0, "R6 zero radicand", 32'(remainder), 0);
            if (VEC_X[i] == 32'd65535)
                check(32'(remainder) == 32'd510, "R6 all-ones remainder", 32'(remainder), 510);
            check_hold(VEC_R[i], $sformatf("vec%0d", i));
        end

        // R8 longer hold with no start
        repeat (5) @(negedge clk);
        check(32'(root) == 32'd209 && ready == 1'b1, "R8 long hold", 32'(root), 209);

        // R7 start during busy ignored
        launch(16'd169);
        start = 1'b1;
        radicand = 16'd4;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (ROOT_W - 4) @(negedge clk);
        check(done == 1'b0, "R7 no early done", 32'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R7 done on time", 32'(done), 1);
        check(32'(root) == 32'd13, "R7 root unchanged", 32'(root), 13);

        // R9 start in the done cycle is accepted
        start = 1'b1;
        radicand = 16'd10000;
        @(negedge clk);
        start = 1'b0;
        radicand = 16'd0;
        finish_one(32'd10000, 32'd100, "R9 back-to-back");
        check_hold(32'd100, "R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule